// File: doc/BRIEF.md
# RS485 Serial Frame Transmitter

This block turns data words into asynchronous serial frames and steers the driver-enable pin of an RS485 line transceiver around each message. A frame is one low start bit, then 7, 8 or 9 data bits sent least-significant bit first, then high stop bits. The line rests high between frames. Bit timing is set by a one-cycle bit-rate tick from outside. The guard windows around a message are counted in core clock cycles.

Before the first start bit, driver-enable rises a programmed number of core cycles early. After the last stop bit, it stays high a programmed number of cycles. A word that arrives while a frame is still being shifted is sent right after that frame, with no gap and no new lead window. A word that arrives during the trailing window waits: the trailing window runs to its end, a fresh lead window follows, and driver-enable stays high through both.

Data enters over a valid/ready stream with a one-word holding slot. `s_ready` is high when the block is enabled and the slot is empty. A word is taken on a clock edge where `s_valid` and `s_ready` are both high. A source that sees `s_ready` low keeps `s_valid` and `s_data` steady until the transfer happens. A word written while the block is disabled is never accepted.

Top module: `rs485_frame_tx`

## Requirements
- R1: After reset, with `en` low: `txd` is 1, and `de`, `busy`, `tx_done` and `s_ready` are 0. The configuration is cleared to length code 00 and zero guard times.
- R2: A frame sends one start bit of 0, then the data bits least-significant bit first, then one stop bit of 1. Each bit stays on `txd` until the next `bit_tick` seen while shifting. Between frames `txd` is 1.
- R3: `cfg_len` selects the number of data bits: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 7, and 2'b11 is treated as 8.
- R4: `de` rises exactly `cfg_lead` core cycles before the start bit appears on `txd`. With `cfg_lead` = 0, `de` rises in the same cycle the start bit begins.
- R5: After the tick that ends the last stop bit, `de` stays high for exactly `cfg_tail` core cycles. With `cfg_tail` = 0, `de` falls in the cycle the stop bit ends.
- R6: A word accepted during the trailing window is held until that window has fully run. A complete `cfg_lead` window then follows before its start bit. `de` stays high the whole time.
- R7: A word accepted before the last stop bit of the current frame ends starts its start bit in the cycle after that stop bit. `de` stays high and there is no lead window.
- R8: `tx_done` is high for exactly one cycle: the first cycle in which `de` is low after a message. `busy` is high from the cycle after a word is accepted until that cycle.
- R9: A configuration write (`cfg_we`) is stored only while `en` is low. A write made while `en` is high has no effect on later frames.
- R10: While `en` is low, `txd` is 1 and `de` is 0 in that same cycle. Any word being sent or waiting is dropped, and the block is idle when `en` returns.
- R11: `s_ready` is high exactly when `en` is high and the holding slot is empty. A held word is not changed until the block takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; low forces the line idle |
| cfg_we | input | 1 | Configuration write strobe, used only while disabled |
| cfg_len | input | 2 | Word-length code |
| cfg_lead | input | GUARD_W | Driver-enable lead time in core cycles |
| cfg_tail | input | GUARD_W | Driver-enable trail time in core cycles |
| bit_tick | input | 1 | One-cycle pulse marking the end of a bit period |
| s_valid | input | 1 | Data word valid |
| s_data | input | DATA_W | Data word, bit 0 sent first |
| s_ready | output | 1 | Holding slot can take a word |
| txd | output | 1 | Serial output line |
| de | output | 1 | Transceiver driver enable |
| busy | output | 1 | A word is queued or a message is in progress |
| tx_done | output | 1 | One-cycle pulse when driver-enable drops |

## Verification
The assertions assume a few things about the inputs:
- `bit_tick` is a single-cycle pulse.
- Guard times and word length change only through a write while disabled.
- `s_data` stays still while a word waits in the slot.

The stimulus keeps within these limits in three ways. It makes configuration writes only with `en` low, except for one deliberate write with `en` high that must be ignored. It produces ticks from a fixed divider. It holds `s_valid` and `s_data` steady until the handshake completes. This way the stream timing, the guard windows and the disable path are all exercised without breaking any assumed rule.

// File: rtl/rs485tx_pkg.sv
package rs485tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } tx_state_t;

  // data bit count for a word-length code (R3)
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    case (code)
      2'b01:   data_bits = 4'd9;
      2'b10:   data_bits = 4'd7;
      default: data_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/rs485tx_cfg.sv
module rs485tx_cfg #(
  parameter int GUARD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [1:0]         len_in,
  input  logic [GUARD_W-1:0] lead_in,
  input  logic [GUARD_W-1:0] tail_in,
  output logic [1:0]         len,
  output logic [GUARD_W-1:0] lead,
  output logic [GUARD_W-1:0] tail
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len  <= '0;
      lead <= '0;
      tail <= '0;
    end else if (we && !en) begin
      len  <= len_in;
      lead <= lead_in;
      tail <= tail_in;
    end
  end

  // R9: settings frozen while enabled
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(len) && $stable(lead) && $stable(tail)));

endmodule

// File: rtl/rs485tx_hold.sv
module rs485tx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  assign in_ready = en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R11: a waiting word is kept intact until taken
  a_r11_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && en) |=> (full && $stable(data)));

  // R11: the controller never takes from an empty slot
  a_r11_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/rs485tx_shift.sv
module rs485tx_shift #(
  parameter int DATA_W    = 9,
  parameter int STOP_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [3:0]        nbits,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              adv,
  output logic              txd_bit,
  output logic              frame_end
);

  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int PW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] frm;
  logic [FRAME_W-2:0] dpad;
  logic [PW-1:0]      pos;
  logic [PW-1:0]      flen;

  assign dpad = {{(FRAME_W - 1 - DATA_W){1'b1}}, ld_data};

  always_comb begin
    frm[0] = 1'b0;
    for (int i = 1; i < FRAME_W; i++) begin
      frm[i] = (i <= int'(nbits)) ? dpad[i-1] : 1'b1;
    end
  end

  assign txd_bit   = sh[0];
  assign frame_end = adv && (pos == flen - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      pos  <= '0;
      flen <= '0;
    end else if (load) begin
      sh   <= frm;
      pos  <= '0;
      flen <= PW'(nbits) + PW'(1 + STOP_BITS);
    end else if (adv) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      pos  <= pos + PW'(1);
    end
  end

  // R2: a bit stays put between ticks
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(sh));

  // R2: every loaded frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd_bit);

endmodule

// File: rtl/rs485tx_ctrl.sv
module rs485tx_ctrl
  import rs485tx_pkg::*;
#(
  parameter int GUARD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               pending,
  input  logic [GUARD_W-1:0] lead,
  input  logic [GUARD_W-1:0] tail,
  input  logic               tick,
  input  logic               frame_end,
  output logic               take,
  output logic               adv,
  output logic               active,
  output logic               shifting,
  output logic               done
);

  tx_state_t          st, st_n;
  logic [GUARD_W-1:0] cnt, cnt_n;
  logic               done_n;

  assign active   = (st != ST_IDLE);
  assign shifting = (st == ST_SHIFT);
  assign adv      = tick && shifting;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    take   = 1'b0;
    done_n = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (pending) begin
          if (lead == '0) begin
            take = 1'b1;
            st_n = ST_SHIFT;
          end else begin
            st_n  = ST_LEAD;
            cnt_n = lead;
          end
        end
      end
      ST_LEAD: begin
        if (cnt <= GUARD_W'(1)) begin
          take = 1'b1;
          st_n = ST_SHIFT;
        end else begin
          cnt_n = cnt - GUARD_W'(1);
        end
      end
      ST_SHIFT: begin
        if (frame_end) begin
          if (pending) begin
            take = 1'b1;
          end else if (tail == '0) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            st_n  = ST_TAIL;
            cnt_n = tail;
          end
        end
      end
      ST_TAIL: begin
        if (cnt <= GUARD_W'(1)) begin
          if (pending) begin
            if (lead == '0) begin
              take = 1'b1;
              st_n = ST_SHIFT;
            end else begin
              st_n  = ST_LEAD;
              cnt_n = lead;
            end
          end else begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        end else begin
          cnt_n = cnt - GUARD_W'(1);
        end
      end
    endcase
    if (!en) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      take   = 1'b0;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      done <= done_n;
    end
  end

  // R10: disabling returns the sequencer to idle
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == ST_IDLE));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion only right after leaving an active state
  a_r8_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((st == ST_IDLE) && ($past(st) != ST_IDLE)));

  // R4: lead counter stays inside the programmed window
  a_r4_lead_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAD) |-> ((cnt != '0) && (cnt <= lead)));

  // R7: a queued word follows the stop bit without leaving shift
  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (en && shifting && frame_end && pending) |=> (st == ST_SHIFT));

  // R6: the trailing window is never cut short
  a_r6_tail_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (st == ST_TAIL) && (cnt > GUARD_W'(1))) |=> (st == ST_TAIL));

endmodule

// File: rtl/rs485_frame_tx.sv
module rs485_frame_tx
  import rs485tx_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int GUARD_W   = 5,
  parameter int STOP_BITS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_len,
  input  logic [GUARD_W-1:0] cfg_lead,
  input  logic [GUARD_W-1:0] cfg_tail,
  input  logic               bit_tick,
  input  logic               s_valid,
  input  logic [DATA_W-1:0]  s_data,
  output logic               s_ready,
  output logic               txd,
  output logic               de,
  output logic               busy,
  output logic               tx_done
);

  logic [1:0]         len_q;
  logic [GUARD_W-1:0] lead_q, tail_q;
  logic               full, take, adv, active, shifting, frame_end, txd_bit;
  logic [DATA_W-1:0]  held;

  rs485tx_cfg #(.GUARD_W(GUARD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .we(cfg_we),
    .len_in(cfg_len), .lead_in(cfg_lead), .tail_in(cfg_tail),
    .len(len_q), .lead(lead_q), .tail(tail_q)
  );

  rs485tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(s_valid), .in_data(s_data), .in_ready(s_ready),
    .take(take), .full(full), .data(held)
  );

  rs485tx_ctrl #(.GUARD_W(GUARD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .pending(full),
    .lead(lead_q), .tail(tail_q), .tick(bit_tick), .frame_end(frame_end),
    .take(take), .adv(adv), .active(active), .shifting(shifting), .done(tx_done)
  );

  rs485tx_shift #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(take), .nbits(data_bits(len_q)),
    .ld_data(held), .adv(adv), .txd_bit(txd_bit), .frame_end(frame_end)
  );

  assign txd  = (en && shifting) ? txd_bit : 1'b1;
  assign de   = en && active;
  assign busy = en && (active || full);

endmodule

// File: tb/tb_rs485_frame_tx.sv
`timescale 1ns/1ps
module tb_rs485_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, cfg_we = 1'b0, bit_tick = 1'b0, s_valid = 1'b0;
  logic [1:0] cfg_len = 2'b00;
  logic [4:0] cfg_lead = '0, cfg_tail = '0;
  logic [8:0] s_data = '0;
  logic       s_ready, txd, de, busy, tx_done;

  int nchk = 0, nfail = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  rs485_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_lead(cfg_lead), .cfg_tail(cfg_tail), .bit_tick(bit_tick),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .txd(txd), .de(de), .busy(busy), .tx_done(tx_done)
  );

  // ---------------- behavioural reference ----------------
  int ph = 0;   // 0 quiet, 1 lead, 2 bits, 3 trail
  int mcnt = 0, m_len = 0, m_lead = 0, m_tail = 0;
  bit m_done = 1'b0;
  bit bq[$];
  logic [8:0] pq[$];

  function automatic int nbits_of(input int code);
    if (code == 1) return 9;
    if (code == 2) return 7;
    return 8;
  endfunction

  task automatic start_frame();
    logic [8:0] d;
    d = pq.pop_front();
    bq.delete();
    bq.push_back(1'b0);
    for (int i = 0; i < nbits_of(m_len); i++) bq.push_back(d[i]);
    bq.push_back(1'b1);
    ph = 2;
  endtask

  task automatic lead_or_send();
    if (m_lead == 0) start_frame();
    else begin ph = 1; mcnt = m_lead; end
  endtask

  always @(posedge clk) begin
    bit had, acc;
    if (!rst_n) begin
      ph = 0; mcnt = 0; m_len = 0; m_lead = 0; m_tail = 0; m_done = 1'b0;
      bq.delete(); pq.delete();
    end else if (!en) begin
      ph = 0; m_done = 1'b0; pq.delete();
      if (cfg_we) begin
        m_len = int'(cfg_len); m_lead = int'(cfg_lead); m_tail = int'(cfg_tail);
      end
    end else begin
      had = (pq.size() > 0);
      acc = s_valid && !had;
      m_done = 1'b0;
      case (ph)
        0: if (had) lead_or_send();
        1: begin mcnt--; if (mcnt == 0) start_frame(); end
        2: if (bit_tick) begin
             void'(bq.pop_front());
             if (bq.size() == 0) begin
               if (had) start_frame();
               else if (m_tail == 0) begin ph = 0; m_done = 1'b1; end
               else begin ph = 3; mcnt = m_tail; end
             end
           end
        default: begin
          mcnt--;
          if (mcnt == 0) begin
            if (had) lead_or_send();
            else begin ph = 0; m_done = 1'b1; end
          end
        end
      endcase
      if (acc) pq.push_back(s_data);
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(txd, (en && ph == 2) ? bq[0] : 1'b1, "txd");
      chk(de, en && (ph != 0), "de");
      chk(busy, en && ((ph != 0) || (pq.size() > 0)), "busy");
      chk(s_ready, en && (pq.size() == 0), "s_ready");
      chk(tx_done, m_done, "tx_done");
    end
  end

  // fixed-rate bit tick, one cycle in four
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      div = (div + 1) % 4;
      bit_tick = (div == 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(); @(posedge clk); #1; endtask

  task automatic send(input logic [8:0] d);
    step();
    s_valid = 1'b1; s_data = d;
    while (!s_ready) step();
    step();
    s_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] l, input int a, input int t);
    step(); en = 1'b0; cfg_we = 1'b1;
    cfg_len = l; cfg_lead = 5'(a); cfg_tail = 5'(t);
    step(); cfg_we = 1'b0; en = 1'b1;
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin step(); g++; end while (busy && g < 5000);
    repeat (3) step();
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog actual=busy expected=idle");
    summary();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();
    @(negedge clk);
    tag = "R1";
    chk(txd, 1'b1, "reset txd");
    chk(de, 1'b0, "reset de");
    chk(busy, 1'b0, "reset busy");
    chk(tx_done, 1'b0, "reset tx_done");
    chk(s_ready, 1'b0, "reset s_ready");
    cmp_on = 1'b1;

    tag = "R2 R8"; step(); en = 1'b1;
    send(9'h0A5); wait_idle();

    tag = "R3 R4 R5"; set_cfg(2'b01, 3, 2);
    send(9'h1C3); wait_idle();
    set_cfg(2'b10, 5, 4);
    send(9'h055); wait_idle();

    tag = "R7 R11"; set_cfg(2'b00, 2, 3);
    send(9'h011); send(9'h0EE); send(9'h07B); wait_idle();

    tag = "R6"; set_cfg(2'b00, 6, 20);
    send(9'h03C);
    while (ph != 3) step();
    repeat (4) step();
    send(9'h0C3); wait_idle();

    tag = "R9"; set_cfg(2'b00, 1, 1);
    step(); cfg_we = 1'b1; cfg_len = 2'b01; cfg_lead = 5'd7; cfg_tail = 5'd9;
    step(); cfg_we = 1'b0;
    send(9'h1A5); wait_idle();

    tag = "R3"; set_cfg(2'b11, 0, 0);
    send(9'h1FF); wait_idle();

    tag = "R10"; set_cfg(2'b00, 2, 3);
    send(9'h081); send(9'h042);
    repeat (14) step();
    en = 1'b0;
    repeat (4) step();
    en = 1'b1;
    repeat (6) step();
    send(9'h0F0); wait_idle();

    summary();
  end

endmodule